// File: doc/BRIEF.md
# Pause-Frame Flow Controller

This block sits beside the transmit datapath of a full-duplex Ethernet MAC and carries out both halves of pause-based flow control. On the local side it builds MAC control frames that ask the link partner to stop or resume. A one-cycle stop request produces a single frame with a programmed quanta. A held resume request produces quanta-zero frames one after another for as long as it stays high. Each frame leaves as a byte stream toward the transmit multiplexer. It starts only when no data frame is in progress, and it is never cut short once started.

On the remote side, a decoded pause indication from the receive parser loads a hold timer. The timer asserts `tx_hold` toward the local transmitter for the requested number of quanta, at 512 bit times per quantum. A separate control can make the block ignore such indications. Another control chooses whether the received pause frame is handed on to the user or absorbed. CRC, preamble and interframe gap are added downstream. The stream is the 60-byte padded frame body without FCS.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A generated frame is exactly 60 consecutive valid bytes. `pf_first` is set on byte 0 only and `pf_last` on byte 59 only. Bytes 0..5 are 01 80 C2 00 00 01. Bytes 6..11 are `station_addr` with bits 47:40 first. Bytes 12..13 are 88 08 and bytes 14..15 are 00 01. Bytes 16..17 carry the quanta, high byte first, and bytes 18..59 are zero.
- R2: A one-cycle `xoff_req` pulse produces exactly one frame whose quanta is `quanta_cfg` taken at frame start. When the block is idle and `tx_busy` is low, byte 0 appears in the cycle after the request edge.
- R3: While `xon_req` is high, frames with quanta 0 follow each other with no idle cycle. After it falls, the frame in flight completes and no new frame starts.
- R4: When a stop request and a resume request are both pending at a frame start, the stop frame (quanta `quanta_cfg`) is sent first.
- R5: No frame starts in a cycle after one where `tx_busy` was high; a deferred request starts the cycle after `tx_busy` falls. Raising `tx_busy` during a frame does not interrupt it.
- R6: `rx_pause_valid` with `ignore_pause` low and quanta N>0 drives `tx_hold` high for exactly N*CLK_PER_QUANTUM cycles, starting the next cycle.
- R7: A new accepted indication during a hold restarts the count from its own quanta. A quanta of 0 drops `tx_hold` in the next cycle.
- R8: With `ignore_pause` high, an indication leaves `tx_hold` as it would have been without it. An idle hold stays low, and a running hold neither restarts nor ends early.
- R9: `rx_pause_to_user` follows `rx_pause_valid` in the same cycle when `fwd_pause` is 1 and stays 0 when it is 0, whatever `ignore_pause` is.
- R10: During and right after reset no frame byte is valid, `tx_hold` is low and no stop request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| xoff_req | input | 1 | One-cycle request for one stop frame |
| xon_req | input | 1 | Level request for repeated resume frames |
| quanta_cfg | input | 16 | Quanta placed in stop frames |
| station_addr | input | 48 | Source address placed in frames |
| ignore_pause | input | 1 | 1: received pause does not hold the transmitter |
| fwd_pause | input | 1 | 1: received pause frames go to the user |
| rx_pause_valid | input | 1 | One-cycle strobe for a decoded received pause |
| rx_pause_quanta | input | 16 | Quanta of the received pause |
| tx_busy | input | 1 | A data frame is being transmitted |
| pf_valid | output | 1 | Frame byte valid |
| pf_data | output | 8 | Frame byte |
| pf_first | output | 1 | First byte of frame |
| pf_last | output | 1 | Last byte of frame |
| tx_hold | output | 1 | Local transmitter must not start a new frame |
| rx_pause_to_user | output | 1 | Received pause frame is passed to the user |

## Verification
The bench compares every byte of each frame against a layout computed from the address and quanta. It sweeps several quanta and addresses, so a wrong byte order or a misplaced field shows up at once. A frame that started while a data frame was running, or broke off when `tx_busy` rose, fails on the start-cycle or contiguity checks. Resume frames are checked for a missing idle cycle between them and for a frame that leaks after the request drops. The hold timer is measured cycle-exact over a sweep of quanta, on reload, on zero release and under ignore, which exposes an off-by-one quantum, a count that adds to rather than replaces the old value, or an ignored indication that still reaches the timer.

// File: rtl/pause_flow_pkg.sv
package pause_flow_pkg;

    typedef enum logic {
        PF_IDLE = 1'b0,
        PF_SEND = 1'b1
    } pf_state_e;

    localparam logic [47:0] PF_DEST_ADDR = 48'h0180_C200_0001;
    localparam logic [15:0] PF_ETHERTYPE = 16'h8808;
    localparam logic [15:0] PF_OPCODE    = 16'h0001;

endpackage

// File: rtl/pause_hold_timer.sv
module pause_hold_timer #(
    parameter int QUANTA_W        = 16,
    parameter int CLK_PER_QUANTUM = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_quanta,
    output logic                hold
);
    localparam int SUB_W = (CLK_PER_QUANTUM > 1) ? $clog2(CLK_PER_QUANTUM) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_QUANTUM - 1);

    typedef struct packed {
        logic [QUANTA_W-1:0] left;
        logic [SUB_W-1:0]    sub;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.left = load_quanta;
            tmr_d.sub  = '0;
        end else if (tmr_q.left != '0) begin
            if (tmr_q.sub == SUB_LAST) begin
                tmr_d.sub  = '0;
                tmr_d.left = tmr_q.left - 1'b1;
            end else begin
                tmr_d.sub = tmr_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign hold = (tmr_q.left != '0);

endmodule

// File: rtl/pause_frame_fmt.sv
module pause_frame_fmt #(
    parameter int QUANTA_W = 16,
    parameter int IDX_W    = 6
) (
    input  logic [IDX_W-1:0]    idx,
    input  logic [47:0]         src_addr,
    input  logic [QUANTA_W-1:0] quanta,
    output logic [7:0]          byte_o
);
    import pause_flow_pkg::*;

    logic [15:0] quanta16;
    assign quanta16 = 16'(quanta);

    always_comb begin
        int i;
        i = int'(idx);
        byte_o = 8'h00;
        if (i < 6)        byte_o = 8'(PF_DEST_ADDR >> (8 * (5 - i)));
        else if (i < 12)  byte_o = 8'(src_addr >> (8 * (11 - i)));
        else if (i == 12) byte_o = PF_ETHERTYPE[15:8];
        else if (i == 13) byte_o = PF_ETHERTYPE[7:0];
        else if (i == 14) byte_o = PF_OPCODE[15:8];
        else if (i == 15) byte_o = PF_OPCODE[7:0];
        else if (i == 16) byte_o = quanta16[15:8];
        else if (i == 17) byte_o = quanta16[7:0];
    end

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl #(
    parameter int QUANTA_W        = 16,
    parameter int CLK_PER_QUANTUM = 64,
    parameter int MIN_BYTES       = 60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xoff_req,
    input  logic                xon_req,
    input  logic [QUANTA_W-1:0] quanta_cfg,
    input  logic [47:0]         station_addr,
    input  logic                ignore_pause,
    input  logic                fwd_pause,
    input  logic                rx_pause_valid,
    input  logic [QUANTA_W-1:0] rx_pause_quanta,
    input  logic                tx_busy,
    output logic                pf_valid,
    output logic [7:0]          pf_data,
    output logic                pf_first,
    output logic                pf_last,
    output logic                tx_hold,
    output logic                rx_pause_to_user
);
    import pause_flow_pkg::*;

    localparam int IDX_W = $clog2(MIN_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MIN_BYTES - 1);

    typedef struct packed {
        pf_state_e           state;
        logic [IDX_W-1:0]    idx;
        logic [QUANTA_W-1:0] quanta;
        logic                xoff_pend;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic want_xoff;
    logic slot_free;

    always_comb begin
        ctl_d     = ctl_q;
        want_xoff = ctl_q.xoff_pend | xoff_req;
        slot_free = (ctl_q.state == PF_IDLE) || (ctl_q.idx == IDX_LAST);
        ctl_d.xoff_pend = want_xoff;
        if (ctl_q.state == PF_SEND && ctl_q.idx != IDX_LAST) begin
            ctl_d.idx = ctl_q.idx + 1'b1;
        end else if (slot_free) begin
            if (!tx_busy && (want_xoff || xon_req)) begin
                ctl_d.state  = PF_SEND;
                ctl_d.idx    = '0;
                ctl_d.quanta = want_xoff ? quanta_cfg : '0;
                if (want_xoff) ctl_d.xoff_pend = 1'b0;
            end else begin
                ctl_d.state = PF_IDLE;
                ctl_d.idx   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= PF_IDLE;
            ctl_q.idx       <= '0;
            ctl_q.quanta    <= '0;
            ctl_q.xoff_pend <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pause_frame_fmt #(
        .QUANTA_W (QUANTA_W),
        .IDX_W    (IDX_W)
    ) u_fmt (
        .idx      (ctl_q.idx),
        .src_addr (station_addr),
        .quanta   (ctl_q.quanta),
        .byte_o   (pf_data)
    );

    pause_hold_timer #(
        .QUANTA_W        (QUANTA_W),
        .CLK_PER_QUANTUM (CLK_PER_QUANTUM)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (rx_pause_valid & ~ignore_pause),
        .load_quanta (rx_pause_quanta),
        .hold        (tx_hold)
    );

    assign pf_valid         = (ctl_q.state == PF_SEND);
    assign pf_first         = pf_valid && (ctl_q.idx == '0);
    assign pf_last          = pf_valid && (ctl_q.idx == IDX_LAST);
    assign rx_pause_to_user = rx_pause_valid & fwd_pause;

endmodule

// File: rtl/pause_flow_checker.sv
module pause_flow_checker #(
    parameter int QUANTA_W  = 16,
    parameter int MIN_BYTES = 60
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ignore_pause,
    input logic                rx_pause_valid,
    input logic [QUANTA_W-1:0] rx_pause_quanta,
    input logic                tx_busy,
    input logic                pf_valid,
    input logic                pf_first,
    input logic                pf_last,
    input logic                tx_hold
);
    int unsigned seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        seen_q <= 0;
        else if (pf_valid) seen_q <= pf_first ? 1 : seen_q + 1;
    end

    a_r1_last_at_length: assert property (@(posedge clk) disable iff (!rst_n)
        pf_last |-> (!pf_first && seen_q == MIN_BYTES - 1));

    a_r1_no_gap_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_last) |=> (pf_valid && !pf_first));

    a_r1_start_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> pf_first);

    a_r5_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pf_first |-> !$past(tx_busy));

    a_r6_hold_on_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_valid && !ignore_pause && rx_pause_quanta != '0) |=> tx_hold);

    a_r7_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pause_valid && !ignore_pause && rx_pause_quanta == '0) |=> !tx_hold);

    a_r8_ignore_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ignore_pause && !tx_hold) |=> !tx_hold);

endmodule

bind pause_flow_ctrl pause_flow_checker #(
    .QUANTA_W  (QUANTA_W),
    .MIN_BYTES (MIN_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ignore_pause    (ignore_pause),
    .rx_pause_valid  (rx_pause_valid),
    .rx_pause_quanta (rx_pause_quanta),
    .tx_busy         (tx_busy),
    .pf_valid        (pf_valid),
    .pf_first        (pf_first),
    .pf_last         (pf_last),
    .tx_hold         (tx_hold)
);

// File: tb/tb_pause_flow_ctrl.sv
module tb_pause_flow_ctrl;
    localparam int CPQ = 4;
    localparam int NB  = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xoff_req = 1'b0, xon_req = 1'b0;
    logic [15:0] quanta_cfg = '0;
    logic [47:0] station_addr = '0;
    logic        ignore_pause = 1'b0, fwd_pause = 1'b0;
    logic        rx_pause_valid = 1'b0;
    logic [15:0] rx_pause_quanta = '0;
    logic        tx_busy = 1'b0;
    logic        pf_valid, pf_first, pf_last, tx_hold, rx_pause_to_user;
    logic [7:0]  pf_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pause_flow_ctrl #(.QUANTA_W(16), .CLK_PER_QUANTUM(CPQ), .MIN_BYTES(NB)) dut (
        .clk(clk), .rst_n(rst_n), .xoff_req(xoff_req), .xon_req(xon_req),
        .quanta_cfg(quanta_cfg), .station_addr(station_addr),
        .ignore_pause(ignore_pause), .fwd_pause(fwd_pause),
        .rx_pause_valid(rx_pause_valid), .rx_pause_quanta(rx_pause_quanta),
        .tx_busy(tx_busy), .pf_valid(pf_valid), .pf_data(pf_data),
        .pf_first(pf_first), .pf_last(pf_last), .tx_hold(tx_hold),
        .rx_pause_to_user(rx_pause_to_user)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [47:0] sa, input logic [15:0] q);
        logic [47:0] da;
        da = 48'h0180C2000001;
        if (i < 6)       return da[47 - 8*i -: 8];
        if (i < 12)      return sa[47 - 8*(i-6) -: 8];
        case (i)
            12: return 8'h88;
            13: return 8'h08;
            14: return 8'h00;
            15: return 8'h01;
            16: return q[15:8];
            17: return q[7:0];
            default: return 8'h00;
        endcase
    endfunction

    // Called at the negedge where byte 0 must be visible; returns at the negedge after byte 59.
    task automatic grab_frame(input logic [15:0] q, input string tag);
        int errs = 0;
        logic [31:0] a = 0, e = 0;
        for (int i = 0; i < NB; i++) begin
            logic [7:0] eb;
            eb = exp_byte(i, station_addr, q);
            if (!pf_valid || pf_data != eb || pf_first != (i == 0) || pf_last != (i == NB-1)) begin
                if (errs == 0) begin
                    a = {i[7:0], pf_valid, pf_first, pf_last, 5'b0, 8'h0, pf_data};
                    e = {i[7:0], 1'b1, 1'(i == 0), 1'(i == NB-1), 5'b0, 8'h0, eb};
                end
                errs++;
            end
            @(negedge clk);
        end
        chk(errs == 0, tag, a, e);
    endtask

    task automatic idle_for(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            if (pf_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic measure_hold(output int cnt);
        cnt = 0;
        while (tx_hold && cnt < 2000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic rx_pulse(input logic [15:0] q, input logic ign);
        rx_pause_quanta = q;
        ignore_pause    = ign;
        rx_pause_valid  = 1'b1;
        @(negedge clk);
        rx_pause_valid  = 1'b0;
        ignore_pause    = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int cnt;
        logic [15:0] qs [3];
        logic [47:0] sas [3];
        qs[0] = 16'h1234; qs[1] = 16'hFFFF; qs[2] = 16'h0001;
        sas[0] = 48'h0011_2233_4455; sas[1] = 48'hA5F0_0FA5_C33C; sas[2] = 48'hFFFF_FFFF_FFFE;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!pf_valid && !tx_hold && !rx_pause_to_user, "R10 outputs in reset",
            {pf_valid, tx_hold, rx_pause_to_user}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_for(5, "R10 no frame after reset");
        chk(!tx_hold, "R10 hold low after reset", tx_hold, 0);

        // R1 R2: stop frames over several quanta and addresses
        for (int k = 0; k < 3; k++) begin
            quanta_cfg   = qs[k];
            station_addr = sas[k];
            xoff_req = 1'b1;
            @(negedge clk);
            xoff_req = 1'b0;
            grab_frame(qs[k], "R1 R2 stop frame layout and start cycle");
            idle_for(3, "R2 single frame per pulse");
        end

        // R3: resume frames back to back, stop after level falls
        station_addr = 48'h0203_0405_0607;
        xon_req = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) grab_frame(16'h0000, "R3 back-to-back resume frame");
        xon_req = 1'b0;
        grab_frame(16'h0000, "R3 frame in flight completes");
        idle_for(6, "R3 no frame after resume request drops");

        // R4: stop wins over resume
        quanta_cfg = 16'h0ABC;
        xon_req  = 1'b1;
        xoff_req = 1'b1;
        @(negedge clk);
        xoff_req = 1'b0;
        grab_frame(16'h0ABC, "R4 stop frame sent first");
        xon_req = 1'b0;
        grab_frame(16'h0000, "R4 resume frame follows");
        idle_for(3, "R4 idle afterwards");

        // R5: deferral while busy and no interruption
        quanta_cfg = 16'h0042;
        tx_busy  = 1'b1;
        xoff_req = 1'b1;
        @(negedge clk);
        xoff_req = 1'b0;
        idle_for(8, "R5 no start while busy");
        tx_busy = 1'b0;
        @(negedge clk);
        tx_busy = 1'b1;
        grab_frame(16'h0042, "R5 deferred frame runs to completion while busy");
        tx_busy = 1'b0;
        idle_for(3, "R5 idle after deferred frame");

        // R6: hold length sweep
        for (int n = 1; n <= 6; n++) begin
            rx_pulse(16'(n), 1'b0);
            measure_hold(cnt);
            chk(cnt == n * CPQ, "R6 hold length", cnt, n * CPQ);
        end

        // R7: reload
        rx_pulse(16'd3, 1'b0);
        repeat (4) @(negedge clk);
        rx_pulse(16'd2, 1'b0);
        measure_hold(cnt);
        chk(cnt == 2 * CPQ, "R7 reload restarts count", cnt, 2 * CPQ);

        // R7: zero release
        rx_pulse(16'd5, 1'b0);
        repeat (2) @(negedge clk);
        rx_pulse(16'd0, 1'b0);
        chk(!tx_hold, "R7 zero quanta releases hold", tx_hold, 0);

        // R8: ignored indication when idle and during a hold
        rx_pulse(16'd3, 1'b1);
        measure_hold(cnt);
        chk(cnt == 0, "R8 ignored pause leaves hold low", cnt, 0);
        rx_pulse(16'd4, 1'b0);
        repeat (3) @(negedge clk);
        rx_pulse(16'd0, 1'b1);
        measure_hold(cnt);
        chk(cnt == 4 * CPQ - 4, "R8 ignored pause does not touch running hold", cnt, 4 * CPQ - 4);
        rx_pulse(16'd9, 1'b1);
        measure_hold(cnt);
        chk(cnt == 0, "R8 ignored long pause no hold", cnt, 0);

        // R9: forwarding truth table
        for (int v = 0; v < 8; v++) begin
            rx_pause_valid  = v[0];
            fwd_pause       = v[1];
            ignore_pause    = v[2];
            rx_pause_quanta = 16'd0;
            #1;
            chk(rx_pause_to_user == (v[0] & v[1]), "R9 forward select",
                rx_pause_to_user, v[0] & v[1]);
            @(negedge clk);
        end
        rx_pause_valid = 1'b0;
        fwd_pause      = 1'b0;
        ignore_pause   = 1'b0;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule